// File: doc/BRIEF.md
# Byte-Bus Loader for an 18-bit Latched DAC

This block sits between an 8-bit, I/O-mapped host write bus and an 18-bit parallel digital-to-analog converter. The converter has a level-sensitive input latch: its inputs pass through while the latch control is low and are held once the control goes high. The host cannot write all 18 bits at once. It writes the code a byte at a time into staging registers at three consecutive I/O addresses. It then writes to a fourth address to commit the word. The commit drives the staged word onto the converter pins and produces a latch-control pulse that meets the converter's setup, hold and minimum-low limits. The limits are given in nanoseconds and converted to clock cycles at elaboration.

The converter pins move only when a commit starts. Staging writes made while a code is being held therefore cannot disturb the analog output. A commit requested while a previous one is still running is queued and started as soon as the running one finishes its hold window. For bipolar ranges, which use offset binary, the output code can reset to midscale so the output comes up at zero volts.

Top module: `dac_byte_loader`

## Requirements
- R1: Only addresses BASE_ADDR to BASE_ADDR+3 (default 0x380..0x383) are decoded. A write to any other address changes no staging bit and starts no commit.
- R2: A write to BASE_ADDR+0 loads code bits 7..0 from bus bits 7..0. A write to BASE_ADDR+1 loads code bits 15..8. A write to BASE_ADDR+2 loads code bits 17..16 from bus bits 1..0, and bus bits 7..2 are ignored.
- R3: A write to BASE_ADDR+3 commits the staged 18-bit word, which then appears on `dac_code`. The data byte of that write is ignored.
- R4: At the start of a commit, `dac_code` takes the new word in the same cycle that `dac_wr_n` goes low. `dac_wr_n` then stays low for exactly LOW_CYC cycles before rising. LOW_CYC is the larger of ceil(SETUP_NS*1000/CLK_PERIOD_PS) and ceil(PULSE_NS*1000/CLK_PERIOD_PS); it is 50 at the defaults.
- R5: After `dac_wr_n` rises, `dac_code` stays unchanged for at least HOLD_CYC = ceil(HOLD_NS*1000/CLK_PERIOD_PS) cycles; this is 30 at the defaults.
- R6: `dac_code` changes only in the cycle where `dac_wr_n` falls. Staging writes never change it directly.
- R7: `busy` is high from the clock edge that samples a commit request until the hold window ends. `dac_wr_n` is never low while `busy` is low.
- R8: A commit requested while busy is queued. It starts in the cycle after the current hold window ends, using the staged word present at that time. Several such requests collapse into one.
- R9: Reset sets `dac_wr_n` high, `busy` low and all staging bits to zero. It sets `dac_code` to zero when BIPOLAR=0, or to 0x20000 (midscale, zero output in offset binary) when BIPOLAR=1.
- R10: A write is taken on the first clock edge at which `bus_wr` is sampled high. A strobe held high for several cycles counts as one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, active high |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_data | input | 8 | Host write data byte |
| dac_code | output | DAC_W | Code driven to the converter data pins |
| dac_wr_n | output | 1 | Converter latch control; transparent while low, captures on rise |
| busy | output | 1 | Commit in progress (low pulse or hold window) |

## Verification
The bench builds the block with BIPOLAR=1 and a 4000 ps clock period, keeping the default nanosecond limits. This makes the low pulse 50 cycles, with the pulse width dominating setup, and the hold window 30 cycles. It also makes the reset code midscale, so a reset value distinct from the cleared staging word can be seen at the pins. With these values the bench can reach a commit queued during a low pulse and launched straight out of a hold window, staging writes landing mid-pulse, a stretched commit strobe, and off-window addresses on both sides of the decoded range.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOW  = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 'h380,
    parameter int unsigned NUM_LANES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_LANES-1:0] lane_ld,
    output logic                 commit_req
);

    logic              wr_prev_d, wr_prev_q;
    logic              wr_evt;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        wr_prev_d = bus_wr;
        wr_evt    = bus_wr & ~wr_prev_q;
        offset    = bus_addr - ADDR_W'(BASE_ADDR);
        for (int i = 0; i < NUM_LANES; i++) begin
            lane_ld[i] = wr_evt && (offset == ADDR_W'(i));
        end
        commit_req = wr_evt && (offset == ADDR_W'(NUM_LANES));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_prev_q <= 1'b0;
        else        wr_prev_q <= wr_prev_d;
    end

endmodule

// File: rtl/dac_stage_regs.sv
module dac_stage_regs #(
    parameter int unsigned DAC_W     = 18,
    parameter int unsigned NUM_LANES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_ld,
    input  logic [7:0]           bus_data,
    output logic [DAC_W-1:0]     staged
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int unsigned LW = ((DAC_W - 8 * g) < 8) ? (DAC_W - 8 * g) : 8;

        logic [LW-1:0] lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (lane_ld[g]) lane_d = bus_data[LW-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end

        assign staged[8*g +: LW] = lane_q;
    end

endmodule

// File: rtl/dac_strobe_seq.sv
module dac_strobe_seq
    import dac_loader_pkg::*;
#(
    parameter int unsigned      DAC_W      = 18,
    parameter int unsigned      LOW_CYC    = 50,
    parameter int unsigned      HOLD_CYC   = 30,
    parameter logic [DAC_W-1:0] RESET_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_req,
    input  logic [DAC_W-1:0] staged,
    output logic [DAC_W-1:0] dac_code,
    output logic             dac_wr_n,
    output logic             busy
);

    localparam int unsigned CNT_W = $clog2(max2(LOW_CYC, HOLD_CYC) + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             wr_n;
        logic             pend;
        logic [DAC_W-1:0] code;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (commit_req) begin
                    seq_d.state = SEQ_LOW;
                    seq_d.code  = staged;
                    seq_d.wr_n  = 1'b0;
                    seq_d.cnt   = CNT_W'(LOW_CYC - 1);
                    seq_d.pend  = 1'b0;
                end
            end
            SEQ_LOW: begin
                if (commit_req) seq_d.pend = 1'b1;
                if (seq_q.cnt == '0) begin
                    seq_d.state = SEQ_HOLD;
                    seq_d.wr_n  = 1'b1;
                    seq_d.cnt   = CNT_W'(HOLD_CYC - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SEQ_HOLD: begin
                if (commit_req) seq_d.pend = 1'b1;
                if (seq_q.cnt == '0) begin
                    if (seq_q.pend || commit_req) begin
                        seq_d.state = SEQ_LOW;
                        seq_d.code  = staged;
                        seq_d.wr_n  = 1'b0;
                        seq_d.cnt   = CNT_W'(LOW_CYC - 1);
                        seq_d.pend  = 1'b0;
                    end else begin
                        seq_d.state = SEQ_IDLE;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= SEQ_IDLE;
            seq_q.cnt   <= '0;
            seq_q.wr_n  <= 1'b1;
            seq_q.pend  <= 1'b0;
            seq_q.code  <= RESET_CODE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign dac_code = seq_q.code;
    assign dac_wr_n = seq_q.wr_n;
    assign busy     = (seq_q.state != SEQ_IDLE);

endmodule

// File: rtl/dac_byte_loader.sv
module dac_byte_loader
    import dac_loader_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned BASE_ADDR     = 'h380,
    parameter int unsigned DAC_W         = 18,
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned SETUP_NS      = 160,
    parameter int unsigned HOLD_NS       = 120,
    parameter int unsigned PULSE_NS      = 200,
    parameter bit          BIPOLAR       = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_data,
    output logic [DAC_W-1:0]  dac_code,
    output logic              dac_wr_n,
    output logic              busy
);

    localparam int unsigned NUM_LANES = ceil_div(DAC_W, 8);
    localparam int unsigned SETUP_CYC = ceil_div(SETUP_NS * 1000, CLK_PERIOD_PS);
    localparam int unsigned PULSE_CYC = ceil_div(PULSE_NS * 1000, CLK_PERIOD_PS);
    localparam int unsigned LOW_CYC   = max2(max2(SETUP_CYC, PULSE_CYC), 1);
    localparam int unsigned HOLD_CYC  = max2(ceil_div(HOLD_NS * 1000, CLK_PERIOD_PS), 1);
    localparam logic [DAC_W-1:0] RESET_CODE = BIPOLAR ? {1'b1, {(DAC_W-1){1'b0}}} : '0;

    logic [NUM_LANES-1:0] lane_ld;
    logic                 commit_req;
    logic [DAC_W-1:0]     staged;

    dac_bus_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .NUM_LANES (NUM_LANES)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .lane_ld    (lane_ld),
        .commit_req (commit_req)
    );

    dac_stage_regs #(
        .DAC_W     (DAC_W),
        .NUM_LANES (NUM_LANES)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_ld  (lane_ld),
        .bus_data (bus_data),
        .staged   (staged)
    );

    dac_strobe_seq #(
        .DAC_W      (DAC_W),
        .LOW_CYC    (LOW_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .RESET_CODE (RESET_CODE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_req (commit_req),
        .staged     (staged),
        .dac_code   (dac_code),
        .dac_wr_n   (dac_wr_n),
        .busy       (busy)
    );

endmodule

// File: rtl/dac_loader_checks.sv
module dac_loader_checks #(
    parameter int unsigned DAC_W    = 18,
    parameter int unsigned LOW_CYC  = 50,
    parameter int unsigned HOLD_CYC = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DAC_W-1:0] dac_code,
    input logic             dac_wr_n,
    input logic             busy
);

    localparam int unsigned CW = $clog2((LOW_CYC > HOLD_CYC ? LOW_CYC : HOLD_CYC) + 2);

    logic [CW-1:0] low_run, high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run  <= '0;
            high_run <= CW'(HOLD_CYC);
        end else if (!dac_wr_n) begin
            low_run  <= low_run + 1'b1;
            high_run <= '0;
        end else begin
            low_run  <= '0;
            if (high_run < CW'(HOLD_CYC)) high_run <= high_run + 1'b1;
        end
    end

    assert_low_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_wr_n) |-> (low_run == CW'(LOW_CYC)));

    assert_hold_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> (high_run >= CW'(HOLD_CYC)));

    assert_code_moves_at_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> $fell(dac_wr_n));

    assert_low_implies_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_wr_n |-> busy);

    assert_busy_drops_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (dac_wr_n && $past(dac_wr_n)));

endmodule

bind dac_byte_loader dac_loader_checks #(
    .DAC_W    (DAC_W),
    .LOW_CYC  (LOW_CYC),
    .HOLD_CYC (HOLD_CYC)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .dac_code (dac_code),
    .dac_wr_n (dac_wr_n),
    .busy     (busy)
);

// File: tb/dac_byte_loader_bench.sv
module dac_byte_loader_bench;

    localparam int ADDR_W   = 16;
    localparam int DAC_W    = 18;
    localparam int BASE     = 'h380;
    localparam int LOW_EXP  = 50;
    localparam int HOLD_EXP = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_data = '0;
    logic [DAC_W-1:0]  dac_code;
    logic              dac_wr_n;
    logic              busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rises = 0;
    int commits = 0;
    logic [DAC_W-1:0] exp_q[$];
    logic [7:0] m_lo = '0, m_mid = '0, m_hi = '0;

    always #2 clk = ~clk;

    dac_byte_loader #(
        .ADDR_W        (ADDR_W),
        .BASE_ADDR     (BASE),
        .DAC_W         (DAC_W),
        .CLK_PERIOD_PS (4000),
        .BIPOLAR       (1'b1)
    ) u_dac_byte_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .dac_code (dac_code),
        .dac_wr_n (dac_wr_n),
        .busy     (busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Driver: one host write, strobe held for hold_cyc cycles
    task automatic bus_write(input int addr, input logic [7:0] data, input int hold_cyc);
        @(posedge clk) #1;
        bus_addr = ADDR_W'(addr);
        bus_data = data;
        bus_wr   = 1'b1;
        case (addr - BASE)
            0: m_lo  = data;
            1: m_mid = data;
            2: m_hi  = data;
            3: begin
                exp_q.push_back({m_hi[1:0], m_mid, m_lo});
                commits++;
            end
            default: ;
        endcase
        repeat (hold_cyc) @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Monitor: low width, hold window, code movement, scoreboard compare
    logic             prev_wr_n = 1'b1;
    logic [DAC_W-1:0] prev_code = '0;
    int               low_cnt = 0;
    int               hi_cnt = HOLD_EXP;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dac_code != prev_code) begin
                check(hi_cnt >= HOLD_EXP, "R5 hold window before code change", hi_cnt, HOLD_EXP);
                check(!dac_wr_n && prev_wr_n, "R6 code moved without falling control",
                      int'(dac_wr_n), 0);
            end
            if (!dac_wr_n) begin
                low_cnt++;
                hi_cnt = 0;
            end else if (hi_cnt < HOLD_EXP) begin
                hi_cnt++;
            end
            if (!prev_wr_n && dac_wr_n) begin
                rises++;
                check(low_cnt == LOW_EXP, "R4 low pulse width", low_cnt, LOW_EXP);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected latch pulse", int'(dac_code), 0);
                end else begin
                    logic [DAC_W-1:0] e;
                    e = exp_q.pop_front();
                    check(dac_code == e, "R3 latched code", int'(dac_code), int'(e));
                end
            end
            if (dac_wr_n) low_cnt = 0;
            prev_wr_n = dac_wr_n;
            prev_code = dac_code;
        end else begin
            prev_code = dac_code;
            prev_wr_n = dac_wr_n;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "watchdog expired", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state, bipolar midscale
        check(dac_wr_n == 1'b1, "R9 control high in reset", int'(dac_wr_n), 1);
        check(busy == 1'b0, "R9 busy low in reset", int'(busy), 0);
        check(dac_code == 18'h20000, "R9 midscale reset code", int'(dac_code), 'h20000);
        rst_n = 1'b1;

        // R9: staging cleared -> first commit gives zero; R7 busy follows request
        bus_write(BASE + 3, 8'h5A, 1);
        @(negedge clk);
        check(busy == 1'b1, "R7 busy after commit request", int'(busy), 1);
        wait_idle();

        // R2/R3: byte lanes, high lane masks bus bits 7..2, commit data ignored
        bus_write(BASE + 0, 8'hA5, 1);
        bus_write(BASE + 1, 8'h3C, 1);
        bus_write(BASE + 2, 8'hFE, 1);
        bus_write(BASE + 3, 8'hFF, 1);
        wait_idle();

        // R6: staging write while idle leaves pins untouched
        bus_write(BASE + 0, 8'h11, 1);
        repeat (3) @(negedge clk);
        check(dac_code == 18'h23CA5, "R6 pins unchanged by staging", int'(dac_code), 'h23CA5);

        // R1: neighbours of the window are ignored
        bus_write(BASE + 4, 8'h77, 1);
        bus_write(BASE - 1, 8'h66, 1);
        repeat (4) @(negedge clk);
        check(dac_wr_n == 1'b1, "R1 no pulse for off-window address", int'(dac_wr_n), 1);
        check(busy == 1'b0, "R1 no busy for off-window address", int'(busy), 0);
        bus_write(BASE + 3, 8'h00, 1);
        repeat (10) @(posedge clk);
        // R8: queue a commit during the low pulse, after changing the mid lane
        bus_write(BASE + 1, 8'h99, 1);
        bus_write(BASE + 3, 8'h00, 1);
        wait_idle();

        // R10: stretched strobes count once
        bus_write(BASE + 0, 8'h42, 4);
        bus_write(BASE + 3, 8'h00, 6);
        wait_idle();
        repeat (10) @(negedge clk);
        check(dac_wr_n == 1'b1 && busy == 1'b0, "R10 stretched commit gives one pulse",
              int'({busy, dac_wr_n}), 1);

        // R2: full scale and midscale
        bus_write(BASE + 0, 8'hFF, 1);
        bus_write(BASE + 1, 8'hFF, 1);
        bus_write(BASE + 2, 8'h03, 1);
        bus_write(BASE + 3, 8'h00, 1);
        wait_idle();
        bus_write(BASE + 0, 8'h00, 1);
        bus_write(BASE + 1, 8'h00, 1);
        bus_write(BASE + 2, 8'h02, 1);
        bus_write(BASE + 3, 8'h00, 1);
        wait_idle();
        repeat (5) @(negedge clk);

        // R8/R10: every accepted commit produced exactly one pulse
        check(rises == commits && exp_q.size() == 0, "R8 pulse count matches commits",
              rises, commits);
        finish_run();
    end

endmodule